// File: doc/BRIEF.md
# Break Protection Controller with Bidirectional Break Pin

This block is the fault-shutdown stage of a PWM timer. Three sources can raise a break event: a filtered break pin (plus a set of comparator fault lines), a software command, and a system-level fault request. When a break event occurs, the block removes the main output enable that gates the PWM outputs and records the event in status flags. The rest of the timer reads the enable and parks its outputs in a safe state.

The break pin can be sensed and driven. In bidirectional mode the block pulls the active-low open-drain pin low while a break is present, so other devices on the same fault line see the fault as well. Because the block senses its own pin, it holds itself in break until software releases it. Software sets a disarm request bit to release the pin. Hardware clears that bit once the application fault has gone, and protection is then armed again. A small register window holds the control word, the flags and the command.

Register map. Address 0 holds the control word: bit 0 break enable, bit 1 polarity, bit 2 bidirectional mode, bit 3 disarm request, bits 7:4 filter code, bit 8 main output enable. Address 1 holds the flags: bit 0 is the break flag and bit 1 is the system-break flag. Address 2 is the command register: bit 0 is the software break.

Top module: `brk_guard`

## Requirements
- R1: After reset the control word and the flags read 0. The main output enable is 0, protection is armed and the pin is not driven.
- R2: Protection is disarmed only when the main output enable is 0, bidirectional mode is 1 and the disarm request is 1. Every other combination leaves it armed.
- R3: A break event clears the main output enable and sets the break flag (address 1, bit 0) on the same clock edge. Writing 0 to a flag bit clears it. Writing 1 to a flag bit leaves it unchanged.
- R4: A system break request sets both the system-break flag (address 1, bit 1) and the break flag, and it clears the main output enable. This happens even when the break enable is 0.
- R5: Writing 1 to bit 0 of address 2 raises a break on that write's clock edge when the break enable is 1. Address 2 always reads 0. When the break enable is 0, this command has no effect.
- R6: While the break enable (control bit 0) is 0, the break pin and the comparator lines cannot raise a break. When it is 1, a comparator line that is high raises a break at the next clock edge.
- R7: Polarity bit 1 selects the active level of the pin: 1 means active high and 0 means active low.
- R8: With filter code 0, a pin change passes through a two-stage synchronizer. The resulting break clears the main output enable at the third clock edge after the change.
- R9: With filter code N greater than 0, a pin change is accepted only after 2*N consecutive synchronized samples at the new level. A shorter pulse is rejected.
- R10: In bidirectional mode the pin is driven low while protection is armed and either a break source is active or the system-break flag is set. The pin is never driven when bidirectional mode is 0.
- R11: A disarm request that software writes stays set while the application fault (pin or comparators) is present. Hardware clears it on the first edge where the fault is absent.
- R12: When no break occurs, software writes the main output enable through control bit 8. A break takes priority over that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| brk_pin_in | input | 1 | Sensed level of the break pad |
| cmp_brk_in | input | NCMP | Comparator fault lines, active high |
| sys_brk_in | input | 1 | System break request, active high |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for reads and writes |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data for reg_addr (combinational) |
| moe_o | output | 1 | Main output enable |
| prot_armed_o | output | 1 | Protection armed |
| brk_pin_drive_o | output | 1 | 1 = pull the open-drain break pad low |

## Verification
Register writes and comparator or system faults take effect at the first clock edge. The same holds for the software command. Pin changes pass through the synchronizer first, so they clear the enable at the third edge with filter code 0, and at edge 3+2N with code N. The pin drive responds combinationally to the armed state, and it clears during the write cycle. A released pin clears the disarm request three edges after the release. The bench drives inputs on falling edges and samples outputs only on falling edges. It counts those edges to land one check just before each due edge and another just after it.

// File: rtl/brk_guard.sv
module brk_guard #(
  parameter int NCMP   = 4,
  parameter int FILT_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              brk_pin_in,
  input  logic [NCMP-1:0]   cmp_brk_in,
  input  logic              sys_brk_in,
  input  logic              wr_en,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              moe_o,
  output logic              prot_armed_o,
  output logic              brk_pin_drive_o
);
  localparam int CNT_W = FILT_W + 1;

  logic              en_q, pol_q, bidir_q, disarm_q, moe_q, bif_q, sif_q;
  logic [FILT_W-1:0] filt_q;
  logic [1:0]        sync_q;
  logic              flt_q;
  logic [CNT_W-1:0]  cnt_q;

  wire s_pin   = sync_q[1];
  wire wr_ctrl = wr_en && (reg_addr == 2'd0);
  wire wr_flag = wr_en && (reg_addr == 2'd1);
  wire wr_cmd  = wr_en && (reg_addr == 2'd2);

  wire [CNT_W-1:0] need = {filt_q, 1'b0} - CNT_W'(1);
  wire pin_lvl = (filt_q == '0) ? s_pin : flt_q;
  wire pin_act = ~(pin_lvl ^ pol_q);
  wire app_raw = pin_act | (|cmp_brk_in);
  wire sw_brk  = wr_cmd & wr_data[0] & en_q;
  wire brk_any = (en_q & app_raw) | sw_brk | sys_brk_in;
  wire armed   = moe_q | ~bidir_q | ~disarm_q;

  assign moe_o           = moe_q;
  assign prot_armed_o    = armed;
  assign brk_pin_drive_o = bidir_q & armed & (brk_any | sif_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], brk_pin_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flt_q <= 1'b0;
      cnt_q <= '0;
    end else if (filt_q == '0 || s_pin == flt_q) begin
      flt_q <= s_pin;
      cnt_q <= '0;
    end else if (cnt_q == need) begin
      flt_q <= s_pin;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q <= 1'b0; pol_q <= 1'b0; bidir_q <= 1'b0; disarm_q <= 1'b0;
      filt_q <= '0;
    end else if (wr_ctrl) begin
      en_q     <= wr_data[0];
      pol_q    <= wr_data[1];
      bidir_q  <= wr_data[2];
      disarm_q <= wr_data[3];
      filt_q   <= wr_data[4 +: FILT_W];
    end else if (disarm_q && !app_raw) begin
      disarm_q <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       moe_q <= 1'b0;
    else if (brk_any) moe_q <= 1'b0;
    else if (wr_ctrl) moe_q <= wr_data[8];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bif_q <= 1'b0;
      sif_q <= 1'b0;
    end else begin
      if (brk_any)                    bif_q <= 1'b1;
      else if (wr_flag && !wr_data[0]) bif_q <= 1'b0;
      if (sys_brk_in)                 sif_q <= 1'b1;
      else if (wr_flag && !wr_data[1]) sif_q <= 1'b0;
    end

  always_comb begin
    rd_data = '0;
    case (reg_addr)
      2'd0: begin
        rd_data[0] = en_q;
        rd_data[1] = pol_q;
        rd_data[2] = bidir_q;
        rd_data[3] = disarm_q;
        rd_data[4 +: FILT_W] = filt_q;
        rd_data[8] = moe_q;
      end
      2'd1: rd_data[1:0] = {sif_q, bif_q};
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/brk_guard_chk.sv
module brk_guard_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              moe_o,
  input logic              prot_armed_o,
  input logic              brk_pin_drive_o,
  input logic              sys_brk_in,
  input logic              bidir_q,
  input logic              bif_q,
  input logic              sif_q,
  input logic [1:0]        reg_addr,
  input logic [DATA_W-1:0] rd_data
);
  assert_enable_keeps_armed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    moe_o |-> prot_armed_o);
  assert_disarm_releases_pin_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_armed_o |-> !brk_pin_drive_o);
  assert_unidir_never_drives_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bidir_q |-> !brk_pin_drive_o);
  assert_flag_with_enable_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bif_q) |-> !moe_o);
  assert_sys_sets_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sys_brk_in |=> (sif_q && bif_q && !moe_o));
  assert_cmd_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd2) |-> (rd_data == '0));
endmodule

bind brk_guard brk_guard_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .moe_o(moe_o), .prot_armed_o(prot_armed_o),
  .brk_pin_drive_o(brk_pin_drive_o), .sys_brk_in(sys_brk_in), .bidir_q(bidir_q),
  .bif_q(bif_q), .sif_q(sif_q), .reg_addr(reg_addr), .rd_data(rd_data)
);

// File: tb/brk_guard_tb.sv
`timescale 1ns/1ps
module brk_guard_tb;
  localparam int NCMP = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_lvl = 1'b1, sys_brk = 1'b0, wr_en = 1'b0;
  logic [NCMP-1:0] cmp = '0;
  logic [1:0] addr = 2'd0;
  logic [15:0] wdata = '0, rdata;
  logic moe, armed, drive, pin;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;
  assign pin = drive ? 1'b0 : ext_lvl;

  brk_guard #(.NCMP(NCMP)) u_dut (
    .clk(clk), .rst_n(rst_n), .brk_pin_in(pin), .cmp_brk_in(cmp), .sys_brk_in(sys_brk),
    .wr_en(wr_en), .reg_addr(addr), .wr_data(wdata), .rd_data(rdata),
    .moe_o(moe), .prot_armed_o(armed), .brk_pin_drive_o(drive));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(2'd0, v); chk("R1 ctrl", v, 16'h0);
    rd(2'd1, v); chk("R1 flags", v, 16'h0);
    chk("R1 moe", moe, 0); chk("R1 armed", armed, 1); chk("R1 drive", drive, 0);
  endtask

  task automatic t_moe_write;
    logic [15:0] v;
    wr(2'd0, 16'h101);
    chk("R12 moe set", moe, 1);
    rd(2'd0, v); chk("R12 ctrl readback", v, 16'h101);
  endtask

  task automatic t_sw_break;
    logic [15:0] v;
    wr(2'd2, 16'h1);
    chk("R5 sw break moe", moe, 0);
    rd(2'd1, v); chk("R3 break flag", v, 16'h1);
    rd(2'd2, v); chk("R5 cmd reads 0", v, 16'h0);
    wr(2'd1, 16'h3);
    rd(2'd1, v); chk("R3 write 1 keeps flag", v, 16'h1);
    wr(2'd1, 16'h0);
    rd(2'd1, v); chk("R3 write 0 clears", v, 16'h0);
  endtask

  task automatic t_disabled;
    logic [15:0] v;
    wr(2'd0, 16'h100);
    wr(2'd2, 16'h1);
    chk("R5 sw ignored when disabled", moe, 1);
    cmp = 4'b0100; cyc(2);
    chk("R6 cmp ignored when disabled", moe, 1);
    rd(2'd1, v); chk("R6 no flag when disabled", v, 16'h0);
    cmp = '0;
  endtask

  task automatic t_cmp;
    logic [15:0] v;
    wr(2'd0, 16'h101);
    cmp = 4'b0001; cyc(1);
    chk("R6 cmp break", moe, 0);
    rd(2'd1, v); chk("R6 cmp flag", v, 16'h1);
    cmp = '0;
    wr(2'd1, 16'h0);
    wr(2'd0, 16'h101);
    wr(2'd0, 16'h101);
    chk("R12 write after break", moe, 1);
  endtask

  task automatic t_polarity;
    wr(2'd0, 16'h000);
    ext_lvl = 1'b0; cyc(4);
    wr(2'd0, 16'h103);
    chk("R7 low idle when active high", moe, 1);
    ext_lvl = 1'b1;
    cyc(2); chk("R8 not before third edge", moe, 1);
    cyc(1); chk("R8 break at third edge", moe, 0);
    wr(2'd0, 16'h000);
    wr(2'd1, 16'h0);
    cyc(4);
  endtask

  task automatic t_filter;
    wr(2'd0, 16'h121);
    ext_lvl = 1'b0; cyc(3); ext_lvl = 1'b1;
    cyc(6); chk("R9 short pulse rejected", moe, 1);
    ext_lvl = 1'b0;
    cyc(6); chk("R9 held before 2N", moe, 1);
    cyc(1); chk("R9 accepted after 2N", moe, 0);
    chk("R10 no drive when unidir", drive, 0);
    ext_lvl = 1'b1;
    wr(2'd0, 16'h000);
    wr(2'd1, 16'h0);
    cyc(6);
  endtask

  task automatic t_bidir;
    logic [15:0] v;
    wr(2'd0, 16'h105);
    ext_lvl = 1'b0; cyc(3);
    chk("R10 drive on break", drive, 1);
    chk("R3 moe cleared", moe, 0);
    cyc(1); ext_lvl = 1'b1; cyc(4);
    chk("R10 pin held by drive", drive, 1);
    chk("R2 armed while moe 0 no disarm", armed, 1);
    wr(2'd0, 16'h00D);
    chk("R2 disarmed", armed, 0);
    chk("R10 released when disarmed", drive, 0);
    cyc(2);
    rd(2'd0, v); chk("R11 disarm kept while fault", v, 16'h00D);
    cyc(1);
    rd(2'd0, v); chk("R11 disarm cleared by hw", v, 16'h005);
    chk("R2 rearmed", armed, 1);
    chk("R10 idle not driven", drive, 0);
    wr(2'd1, 16'h0);
  endtask

  task automatic t_arm_table;
    logic [15:0] v;
    wr(2'd0, 16'h10D);
    chk("R2 moe 1 keeps armed", armed, 1);
    rd(2'd0, v); chk("R11 disarm readback", v, 16'h10D);
    cyc(1);
    rd(2'd0, v); chk("R11 cleared with no fault", v, 16'h105);
    wr(2'd0, 16'h00C);
    chk("R2 all three conditions", armed, 0);
    wr(2'd0, 16'h008);
    chk("R2 bidir 0 keeps armed", armed, 1);
    cyc(1);
  endtask

  task automatic t_sys;
    logic [15:0] v;
    wr(2'd0, 16'h104);
    wr(2'd1, 16'h0);
    @(negedge clk); sys_brk = 1'b1;
    @(negedge clk); sys_brk = 1'b0;
    chk("R4 moe cleared", moe, 0);
    rd(2'd1, v); chk("R4 both flags", v, 16'h3);
    chk("R10 drive from sys flag", drive, 1);
    cyc(2); chk("R10 drive held by sys flag", drive, 1);
    wr(2'd1, 16'h1);
    rd(2'd1, v); chk("R3 sys flag cleared only", v, 16'h1);
    chk("R10 drive stops after flag cleared", drive, 0);
  endtask

  initial begin
    cyc(3); rst_n = 1'b1; cyc(1);
    t_reset(); t_moe_write(); t_sw_break(); t_disabled(); t_cmp();
    t_polarity(); t_filter(); t_bidir(); t_arm_table(); t_sys();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #50000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule